// File: doc/BRIEF.md
# GPIO Pin Control Register Unit

This block holds the per-pin configuration and data registers of a general-purpose I/O pad controller. It also generates the pad-side controls. Each pin owns two words on a simple word-wide register bus, a control word and an I/O word.

The control word chooses the pin's alternate function, its bias (none, pull-down, bus keeper, pull-up), a drive-strength code and an output enable. The I/O word holds the value the pin drives and returns the pad level after a two-flop synchronizer.

While the function select is zero, the GPIO registers drive the pad. Any other selection hands the pad's output data and output enable to that function's own signals.

The bus writes on a clock edge when `bus_wr` is high. Reads are combinational from `bus_addr`. Address bit 0 selects the word (0 = control, 1 = I/O), and the remaining address bits select the pin.

Top module: `gpio_pinctl_bank`

## Requirements
- R1: After reset, every control word and every I/O output bit read as 0: function 0, no bias, drive code 0 (2 mA), input. All pad-side outputs are then 0.
- R2: The control word layout is: bit 0 = output enable, bits 3:1 = drive code, bits 5:4 = bias, bits 10:8 = function select. All other bits read as 0 whatever was written.
- R3: Bias code 0 requests no bias, 1 requests pull-down, 2 requests the keeper and 3 requests pull-up. At most one of `pad_pu`, `pad_pd`, `pad_keep` is high for a pin.
- R4: The drive code c (selecting (c+1)*2 mA, 2 to 16 mA) appears unchanged on the pin's 3-bit slice of `pad_drv`.
- R5: With function 0, `pad_oe` follows the control word's output-enable bit and `pad_out` follows the I/O word's output bit.
- R6: With function f in 1..7, `pad_out` and `pad_oe` of pin p come from `fn_out[p*7+f-1]` and `fn_oe[p*7+f-1]`. The GPIO output bit and output enable then have no effect on the pad.
- R7: I/O word bit 0 shows the pad input level two clock edges after it changes, through a two-flop synchronizer.
- R8: I/O word bit 1 is the stored output value and is written from bus data bit 1. A write to the read-only bit 0 is ignored, and all other I/O bits read as 0.
- R9: `pad_keep_lvl` of a pin equals the synchronized pad level, so a keeper holds the last sampled value.
- R10: A bus write changes only the addressed word of the addressed pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | {pin index, word select} |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed word |
| pad_in | input | NUM_PINS | Raw pad input levels |
| fn_out | input | NUM_PINS*(NUM_FN-1) | Output data of alternate functions 1..7 per pin |
| fn_oe | input | NUM_PINS*(NUM_FN-1) | Output enable of alternate functions 1..7 per pin |
| pad_out | output | NUM_PINS | Pad output data |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pu | output | NUM_PINS | Pull-up request |
| pad_pd | output | NUM_PINS | Pull-down request |
| pad_keep | output | NUM_PINS | Keeper request |
| pad_keep_lvl | output | NUM_PINS | Level the keeper holds |
| pad_drv | output | NUM_PINS*3 | Drive-strength code per pin |

## Verification
The bench checks that reserved control and I/O bits read 0 after an all-ones write. A design that stored or echoed those bits would return non-zero data there.

It checks that writing the input bit cannot change the stored output. A wrong bit position would flip `pad_out`.

It checks the two-edge input latency by sampling both one edge and two edges after a pad change. A design with one flop or three flops would show the level in the wrong cycle.

It walks all four bias codes and all eight drive codes, and switches a pin between GPIO and an alternate function. A design that swapped pull-up and pull-down, or let the GPIO output leak through while a function is selected, would show the wrong pad outputs.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // control word field positions
  localparam int CTL_OE_BIT   = 0;
  localparam int CTL_DRV_LO   = 1;
  localparam int CTL_BIAS_LO  = 4;
  localparam int CTL_FN_LO    = 8;
  localparam int DRV_W        = 3;
  localparam int BIAS_W       = 2;
  // I/O word bit positions
  localparam int IO_IN_BIT    = 0;
  localparam int IO_OUT_BIT   = 1;

  typedef enum logic [BIAS_W-1:0] {
    BIAS_NONE = 2'd0,
    BIAS_DOWN = 2'd1,
    BIAS_KEEP = 2'd2,
    BIAS_UP   = 2'd3
  } bias_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [1:0] ff_q;
  logic [1:0] ff_d;

  always_comb ff_d = {ff_q[0], d_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= 2'b00;
    else        ff_q <= ff_d;
  end

  assign q_out = ff_q[1];

  // history counter so the latency check only looks back over valid cycles
  logic [1:0] hist_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hist_q <= 2'd0;
    else if (hist_q != 2'd2) hist_q <= hist_q + 2'd1;
  end

  // R7
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_q == 2'd2) |-> (q_out == $past(d_in, 2)));
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_FN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_io,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pad_in,
  input  logic [NUM_FN-2:0] fn_out,
  input  logic [NUM_FN-2:0] fn_oe,
  output logic [DATA_W-1:0] ctl_word,
  output logic [DATA_W-1:0] io_word,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              pad_pu,
  output logic              pad_pd,
  output logic              pad_keep,
  output logic              pad_keep_lvl,
  output logic [DRV_W-1:0]  pad_drv
);
  localparam int FN_W = (NUM_FN > 1) ? $clog2(NUM_FN) : 1;

  logic             oe_q,   oe_d;
  logic [DRV_W-1:0] drv_q,  drv_d;
  bias_e            bias_q, bias_d;
  logic [FN_W-1:0]  fn_q,   fn_d;
  logic             out_q,  out_d;
  logic             in_sync;
  logic [FN_W-1:0]  fn_idx;

  gpio_sync2 u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pad_in),
    .q_out (in_sync)
  );

  // next state
  always_comb begin
    oe_d   = oe_q;
    drv_d  = drv_q;
    bias_d = bias_q;
    fn_d   = fn_q;
    out_d  = out_q;
    if (wr_ctl) begin
      oe_d   = wdata[CTL_OE_BIT];
      drv_d  = wdata[CTL_DRV_LO +: DRV_W];
      bias_d = bias_e'(wdata[CTL_BIAS_LO +: BIAS_W]);
      fn_d   = wdata[CTL_FN_LO +: FN_W];
    end
    if (wr_io) out_d = wdata[IO_OUT_BIT];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      drv_q  <= '0;
      bias_q <= BIAS_NONE;
      fn_q   <= '0;
      out_q  <= 1'b0;
    end else begin
      oe_q   <= oe_d;
      drv_q  <= drv_d;
      bias_q <= bias_d;
      fn_q   <= fn_d;
      out_q  <= out_d;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  // readback
  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_OE_BIT]              = oe_q;
    ctl_word[CTL_DRV_LO +: DRV_W]     = drv_q;
    ctl_word[CTL_BIAS_LO +: BIAS_W]   = bias_q;
    ctl_word[CTL_FN_LO +: FN_W]       = fn_q;
    io_word = '0;
    io_word[IO_IN_BIT]  = in_sync;
    io_word[IO_OUT_BIT] = out_q;
  end

  // pad output routing
  always_comb begin
    fn_idx = fn_q - FN_W'(1);
    if (fn_q == '0) begin
      pad_out = out_q;
      pad_oe  = oe_q;
    end else begin
      pad_out = fn_out[fn_idx];
      pad_oe  = fn_oe[fn_idx];
    end
  end

  // bias decode and drive
  always_comb begin
    pad_pu       = (bias_q == BIAS_UP);
    pad_pd       = (bias_q == BIAS_DOWN);
    pad_keep     = (bias_q == BIAS_KEEP);
    pad_keep_lvl = in_sync;
    pad_drv      = drv_q;
  end

  // R3
  bias_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pad_pu, pad_pd, pad_keep}));

  // R2
  ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ctl_word[CTL_OE_BIT] == $past(wdata[CTL_OE_BIT]) &&
                pad_drv == $past(wdata[CTL_DRV_LO +: DRV_W])));

  // R8
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_io |=> (io_word[IO_OUT_BIT] == $past(wdata[IO_OUT_BIT])));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_io |=> $stable(io_word[IO_OUT_BIT]));
endmodule

// File: rtl/gpio_pinctl_bank.sv
module gpio_pinctl_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int NUM_FN   = 8,
  parameter int DATA_W   = 32,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ADDR_W  = PIN_W + 1,
  localparam int FNV_W   = NUM_PINS * (NUM_FN - 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NUM_PINS-1:0]       pad_in,
  input  logic [FNV_W-1:0]          fn_out,
  input  logic [FNV_W-1:0]          fn_oe,
  output logic [NUM_PINS-1:0]       pad_out,
  output logic [NUM_PINS-1:0]       pad_oe,
  output logic [NUM_PINS-1:0]       pad_pu,
  output logic [NUM_PINS-1:0]       pad_pd,
  output logic [NUM_PINS-1:0]       pad_keep,
  output logic [NUM_PINS-1:0]       pad_keep_lvl,
  output logic [NUM_PINS*DRV_W-1:0] pad_drv
);
  localparam int FPP = NUM_FN - 1;

  logic              rst_n_int;
  logic [PIN_W-1:0]  pin_sel;
  logic              io_sel;
  logic [DATA_W-1:0] ctl_words [NUM_PINS];
  logic [DATA_W-1:0] io_words  [NUM_PINS];

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign pin_sel = bus_addr[ADDR_W-1:1];
  assign io_sel  = bus_addr[0];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit;
    assign hit = (pin_sel == PIN_W'(p));

    gpio_pin_slice #(
      .DATA_W (DATA_W),
      .NUM_FN (NUM_FN)
    ) u_slice (
      .clk          (clk),
      .rst_n        (rst_n_int),
      .wr_ctl       (bus_wr && hit && !io_sel),
      .wr_io        (bus_wr && hit &&  io_sel),
      .wdata        (bus_wdata),
      .pad_in       (pad_in[p]),
      .fn_out       (fn_out[p*FPP +: FPP]),
      .fn_oe        (fn_oe[p*FPP +: FPP]),
      .ctl_word     (ctl_words[p]),
      .io_word      (io_words[p]),
      .pad_out      (pad_out[p]),
      .pad_oe       (pad_oe[p]),
      .pad_pu       (pad_pu[p]),
      .pad_pd       (pad_pd[p]),
      .pad_keep     (pad_keep[p]),
      .pad_keep_lvl (pad_keep_lvl[p]),
      .pad_drv      (pad_drv[p*DRV_W +: DRV_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (pin_sel == PIN_W'(p)) bus_rdata = io_sel ? io_words[p] : ctl_words[p];
    end
  end
endmodule

// File: tb/sim_gpio_pinctl_bank.sv
`timescale 1ns/1ps
module sim_gpio_pinctl_bank;
  localparam int NP = 4;
  localparam int NF = 8;
  localparam int FPP = NF - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pad_in;
  logic [NP*FPP-1:0] fn_out, fn_oe;
  logic [NP-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_keep, pad_keep_lvl;
  logic [NP*3-1:0] pad_drv;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gpio_pinctl_bank #(.NUM_PINS(NP), .NUM_FN(NF), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .fn_out(fn_out), .fn_oe(fn_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_keep(pad_keep),
    .pad_keep_lvl(pad_keep_lvl), .pad_drv(pad_drv));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctl(input int fn, input int bias, input int drv, input int oe);
    return 32'((fn << 8) | (bias << 4) | (drv << 1) | oe);
  endfunction

  task automatic wr(input int pin, input bit io, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {2'(pin), io}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int pin, input bit io, output logic [31:0] d);
    bus_addr = {2'(pin), io};
    #0.5;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int p = 0; p < NP; p++) begin
      rd(p, 1'b0, d); chk("R1 ctl reset", d, 32'h0);
      rd(p, 1'b1, d); chk("R1 io reset", d & 32'h2, 32'h0);
    end
    chk("R1 pad outputs", {pad_out, pad_oe, pad_pu, pad_pd, pad_keep}, 32'h0);
    chk("R1 drive", 32'(pad_drv), 32'h0);
  endtask

  task automatic t_ctl_layout;
    logic [31:0] d;
    wr(1, 1'b0, 32'hFFFF_FFFF);
    rd(1, 1'b0, d); chk("R2 ctl layout readback", d, 32'h0000_073F);
    rd(0, 1'b0, d); chk("R10 neighbour ctl untouched", d, 32'h0);
    rd(1, 1'b1, d); chk("R10 own io untouched", d & 32'h2, 32'h0);
    wr(1, 1'b0, mk_ctl(2, 1, 5, 0));
    rd(1, 1'b0, d); chk("R2 ctl fields", d, 32'h0000_021A);
    wr(1, 1'b0, 32'h0);
  endtask

  task automatic t_bias;
    for (int b = 0; b < 4; b++) begin
      wr(2, 1'b0, mk_ctl(0, b, 0, 0));
      chk($sformatf("R3 bias %0d pu/pd/keep", b),
          {29'h0, pad_pu[2], pad_pd[2], pad_keep[2]},
          (b == 3) ? 32'h4 : (b == 1) ? 32'h2 : (b == 2) ? 32'h1 : 32'h0);
    end
    wr(2, 1'b0, 32'h0);
  endtask

  task automatic t_drive;
    for (int c = 0; c < 8; c++) begin
      wr(3, 1'b0, mk_ctl(0, 0, c, 0));
      chk($sformatf("R4 drive code %0d (%0d mA)", c, (c + 1) * 2), 32'(pad_drv[9 +: 3]), 32'(c));
    end
    chk("R10 other pins drive", 32'(pad_drv[8:0]), 32'h0);
    wr(3, 1'b0, 32'h0);
  endtask

  task automatic t_gpio_out;
    logic [31:0] d;
    wr(0, 1'b0, mk_ctl(0, 0, 0, 1));
    wr(0, 1'b1, 32'h2);
    chk("R5 gpio oe", 32'(pad_oe[0]), 32'h1);
    chk("R5 gpio out high", 32'(pad_out[0]), 32'h1);
    wr(0, 1'b1, 32'h0);
    chk("R5 gpio out low", 32'(pad_out[0]), 32'h0);
    wr(0, 1'b1, 32'h1);
    chk("R8 in-bit write ignored on pad", 32'(pad_out[0]), 32'h0);
    rd(0, 1'b1, d); chk("R8 io readback", d, {31'h0, pad_in[0]});
    wr(0, 1'b1, 32'hFFFF_FFFF);
    rd(0, 1'b1, d); chk("R8 io reserved bits", d & 32'hFFFF_FFFE, 32'h2);
    wr(0, 1'b0, mk_ctl(0, 0, 0, 0));
    chk("R5 gpio oe cleared", 32'(pad_oe[0]), 32'h0);
    wr(0, 1'b1, 32'h0);
  endtask

  task automatic t_func;
    wr(3, 1'b1, 32'h2);
    wr(3, 1'b0, mk_ctl(5, 0, 0, 1));
    @(negedge clk);
    fn_out = '0; fn_oe = '0;
    #0.5;
    chk("R6 function overrides gpio out", 32'(pad_out[3]), 32'h0);
    chk("R6 function overrides gpio oe", 32'(pad_oe[3]), 32'h0);
    fn_out[3*FPP + 4] = 1'b1; fn_oe[3*FPP + 4] = 1'b1;
    #0.5;
    chk("R6 function 5 out", 32'(pad_out[3]), 32'h1);
    chk("R6 function 5 oe", 32'(pad_oe[3]), 32'h1);
    fn_out[3*FPP + 3] = 1'b0; fn_out[3*FPP + 4] = 1'b0;
    fn_out[3*FPP + 3] = 1'b1;
    #0.5;
    chk("R6 other function ignored", 32'(pad_out[3]), 32'h0);
    wr(3, 1'b0, mk_ctl(0, 0, 0, 1));
    chk("R5 back to gpio", 32'(pad_out[3]), 32'h1);
    fn_out = '0; fn_oe = '0;
    wr(3, 1'b0, 32'h0);
    wr(3, 1'b1, 32'h0);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    @(negedge clk);
    pad_in[1] = 1'b1;
    @(negedge clk);
    rd(1, 1'b1, d); chk("R7 one edge after rise", d & 32'h1, 32'h0);
    @(negedge clk);
    rd(1, 1'b1, d); chk("R7 two edges after rise", d & 32'h1, 32'h1);
    pad_in[1] = 1'b0;
    @(negedge clk);
    rd(1, 1'b1, d); chk("R7 one edge after fall", d & 32'h1, 32'h1);
    @(negedge clk);
    rd(1, 1'b1, d); chk("R7 two edges after fall", d & 32'h1, 32'h0);
  endtask

  task automatic t_keeper;
    wr(2, 1'b0, mk_ctl(0, 2, 0, 0));
    @(negedge clk);
    pad_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 keeper level high", 32'(pad_keep_lvl[2]), 32'h1);
    chk("R3 keeper request", 32'(pad_keep[2]), 32'h1);
    pad_in[2] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 keeper level low", 32'(pad_keep_lvl[2]), 32'h0);
    wr(2, 1'b0, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; fn_out = '0; fn_oe = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctl_layout();
    t_bias();
    t_drive();
    t_gpio_out();
    t_func();
    t_sync();
    t_keeper();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule